// File: doc/BRIEF.md
# Sensor Register Bank with Pointer

This block is the byte-level register file behind a serial-bus slave in a temperature monitor. The bus front end gives it decoded bytes and strobes. The bank does not see bus bits, start or stop conditions, or acknowledge timing. A transaction-start flag arms the bank. The first data byte after that flag goes into an internal pointer, which has no address of its own. Every later data byte in the transaction, and every later read request, uses whatever register the pointer names. The pointer does not auto-increment.

Each writable configuration and limit register has two addresses: one for reading and a different one for writing. The bank treats the two address maps separately. A byte sent to a read address is ignored. A read from a write address returns zero. One write address is a trigger only: writing to it gives a one-cycle conversion request and stores nothing. The two temperature readings come only from a side port on the measurement logic. All stored fields are also driven straight out to the measurement and alert logic.

Top module: `sensor_regbank`

## Requirements
- R1: After reset, reads return 0x80 at 0x00 and 0x01, 0x00 at 0x03, 0x02 at 0x04, 0x7F at 0x05 and 0x07, 0xC9 at 0x06 and 0x08, and 0x00 at 0x11.
- R2: When `start_i` is high, or has been seen since the last data byte, the next byte on `wr_en_i` loads the pointer and changes no stored register.
- R3: Every other write byte goes to the register the pointer names, and the pointer keeps its value, so repeated bytes hit the same register.
- R4: Read map: 0x00 local reading, 0x01 remote reading, 0x03 configuration, 0x04 rate, 0x05 local high, 0x06 local low, 0x07 remote high, 0x08 remote low, 0x11 offset.
- R5: Write map: 0x09 configuration, 0x0A rate, 0x0B local high, 0x0C local low, 0x0D remote high, 0x0E remote low, 0x11 offset.
- R6: A rate write stores only data bits 2:0. Read bits 7:3 at 0x04 are always zero.
- R7: A data byte written to 0x0F drives `one_shot_o` high for exactly the next cycle and stores nothing. No other byte raises `one_shot_o`.
- R8: A data byte sent to an address outside the write map (read-only addresses such as 0x00 to 0x08 and 0xFE, or undefined addresses) changes no stored register.
- R9: Reads of write-only addresses (0x09 to 0x0F) and undefined addresses return 0x00.
- R10: Read address 0xFE returns 0x41. Read address 0xFF returns a byte whose upper nibble is 0x3.
- R11: The two temperature readings change only through `meas_loc_we_i` / `meas_rem_we_i`, which load the value on the matching input.
- R12: The field outputs always equal the stored values that the read map returns.
- R13: `rd_data_o` shows the addressed byte in the cycle after `rd_en_i`. It holds its value in every cycle without `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start of a write transaction |
| wr_en_i | input | 1 | Write-byte strobe |
| wr_data_i | input | 8 | Write byte |
| rd_en_i | input | 1 | Read request at the pointer |
| rd_data_o | output | 8 | Registered read data |
| meas_loc_we_i | input | 1 | Load local reading |
| meas_loc_i | input | 8 | Local reading value |
| meas_rem_we_i | input | 1 | Load remote reading |
| meas_rem_i | input | 8 | Remote reading value |
| cfg_o | output | 8 | Configuration byte |
| conv_rate_o | output | 3 | Conversion rate code |
| loc_high_o | output | 8 | Local high limit |
| loc_low_o | output | 8 | Local low limit |
| rem_high_o | output | 8 | Remote high limit |
| rem_low_o | output | 8 | Remote low limit |
| rem_offset_o | output | 8 | Remote offset, two's complement |
| loc_temp_o | output | 8 | Stored local reading |
| rem_temp_o | output | 8 | Stored remote reading |
| one_shot_o | output | 1 | Single-conversion request pulse |

## Verification
A corrupted pointer is visible at the ports at the next read: the byte comes from a neighbouring register. At the next write, a different field output moves, one cycle after the byte. A stored register that takes a stray byte shows on its field output in the very next cycle. It does so even when nothing reads it, so the bench compares every field output against its model after each bus byte. A decode slip between the two maps shows up as a nonzero read at a write-only address, or as a register that no longer reads back what was written.

// File: rtl/sensor_regbank_pkg.sv
package sensor_regbank_pkg;

    typedef logic [7:0] byte_t;

    // read-side addresses
    localparam byte_t RA_LOC_T   = 8'h00;
    localparam byte_t RA_REM_T   = 8'h01;
    localparam byte_t RA_CFG     = 8'h03;
    localparam byte_t RA_RATE    = 8'h04;
    localparam byte_t RA_LOC_HI  = 8'h05;
    localparam byte_t RA_LOC_LO  = 8'h06;
    localparam byte_t RA_REM_HI  = 8'h07;
    localparam byte_t RA_REM_LO  = 8'h08;
    localparam byte_t RA_ID      = 8'hFE;
    localparam byte_t RA_REV     = 8'hFF;

    // write-side addresses
    localparam byte_t WA_CFG     = 8'h09;
    localparam byte_t WA_RATE    = 8'h0A;
    localparam byte_t WA_LOC_HI  = 8'h0B;
    localparam byte_t WA_LOC_LO  = 8'h0C;
    localparam byte_t WA_REM_HI  = 8'h0D;
    localparam byte_t WA_REM_LO  = 8'h0E;
    localparam byte_t WA_TRIGGER = 8'h0F;

    // shared read/write address
    localparam byte_t XA_OFFSET  = 8'h11;

    localparam int RATE_W = 3;

    typedef struct packed {
        byte_t             cfg;
        logic [RATE_W-1:0] rate;
        byte_t             loc_hi;
        byte_t             loc_lo;
        byte_t             rem_hi;
        byte_t             rem_lo;
        byte_t             offset;
        byte_t             loc_t;
        byte_t             rem_t;
    } bank_t;

    typedef struct packed {
        logic cfg;
        logic rate;
        logic loc_hi;
        logic loc_lo;
        logic rem_hi;
        logic rem_lo;
        logic offset;
        logic trigger;
    } wstb_t;

    localparam bank_t BANK_RESET = '{
        cfg:    8'h00,
        rate:   3'd2,
        loc_hi: 8'h7F,
        loc_lo: 8'hC9,
        rem_hi: 8'h7F,
        rem_lo: 8'hC9,
        offset: 8'h00,
        loc_t:  8'h80,
        rem_t:  8'h80
    };

    function automatic wstb_t decode_write(input byte_t addr, input logic en);
        wstb_t s;
        s = '0;
        if (en) begin
            case (addr)
                WA_CFG:     s.cfg     = 1'b1;
                WA_RATE:    s.rate    = 1'b1;
                WA_LOC_HI:  s.loc_hi  = 1'b1;
                WA_LOC_LO:  s.loc_lo  = 1'b1;
                WA_REM_HI:  s.rem_hi  = 1'b1;
                WA_REM_LO:  s.rem_lo  = 1'b1;
                XA_OFFSET:  s.offset  = 1'b1;
                WA_TRIGGER: s.trigger = 1'b1;
                default:    s         = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/regbank_ptr.sv
module regbank_ptr
    import sensor_regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  wr_en_i,
    input  byte_t wr_data_i,
    output byte_t ptr_o,
    output logic  data_we_o
);
    logic  armed_q;
    logic  ptr_byte;
    byte_t ptr_q;

    assign ptr_byte  = wr_en_i & (start_i | armed_q);
    assign data_we_o = wr_en_i & ~ptr_byte;
    assign ptr_o     = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= 8'h00;
            armed_q <= 1'b1;
        end else begin
            if (wr_en_i)      armed_q <= 1'b0;
            else if (start_i) armed_q <= 1'b1;
            if (ptr_byte)     ptr_q   <= wr_data_i;
        end
    end

    AST_PTR_LOAD_ON_START: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && start_i) |=> (ptr_o == $past(wr_data_i))); // R2
    AST_PTR_HOLD_ON_DATA: assert property (@(posedge clk) disable iff (rst)
        data_we_o |=> $stable(ptr_o)); // R3
    AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(ptr_o)); // R3
endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import sensor_regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wstb_t wstb_i,
    input  byte_t wr_data_i,
    input  logic  meas_loc_we_i,
    input  byte_t meas_loc_i,
    input  logic  meas_rem_we_i,
    input  byte_t meas_rem_i,
    output bank_t bank_o,
    output logic  trigger_o
);
    bank_t bank_q;
    logic  trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= BANK_RESET;
            trig_q <= 1'b0;
        end else begin
            trig_q <= wstb_i.trigger;
            if (wstb_i.cfg)    bank_q.cfg    <= wr_data_i;
            if (wstb_i.rate)   bank_q.rate   <= wr_data_i[RATE_W-1:0];
            if (wstb_i.loc_hi) bank_q.loc_hi <= wr_data_i;
            if (wstb_i.loc_lo) bank_q.loc_lo <= wr_data_i;
            if (wstb_i.rem_hi) bank_q.rem_hi <= wr_data_i;
            if (wstb_i.rem_lo) bank_q.rem_lo <= wr_data_i;
            if (wstb_i.offset) bank_q.offset <= wr_data_i;
            if (meas_loc_we_i) bank_q.loc_t  <= meas_loc_i;
            if (meas_rem_we_i) bank_q.rem_t  <= meas_rem_i;
        end
    end

    assign bank_o    = bank_q;
    assign trigger_o = trig_q;

    AST_LOC_T_SIDE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !meas_loc_we_i |=> $stable(bank_o.loc_t)); // R11
    AST_REM_T_SIDE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !meas_rem_we_i |=> $stable(bank_o.rem_t)); // R11
    AST_CFG_NO_STRAY: assert property (@(posedge clk) disable iff (rst)
        !wstb_i.cfg |=> $stable(bank_o.cfg)); // R8
    AST_OFFSET_NO_STRAY: assert property (@(posedge clk) disable iff (rst)
        !wstb_i.offset |=> $stable(bank_o.offset)); // R8
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
    import sensor_regbank_pkg::*;
#(
    parameter byte_t      DEV_ID   = 8'h41,
    parameter logic [3:0] REV_STEP = 4'h1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en_i,
    input  byte_t ptr_i,
    input  bank_t bank_i,
    output byte_t rd_data_o
);
    localparam byte_t REV_BYTE = {4'h3, REV_STEP};

    byte_t sel;
    byte_t rd_q;

    always_comb begin
        case (ptr_i)
            RA_LOC_T:  sel = bank_i.loc_t;
            RA_REM_T:  sel = bank_i.rem_t;
            RA_CFG:    sel = bank_i.cfg;
            RA_RATE:   sel = {{(8-RATE_W){1'b0}}, bank_i.rate};
            RA_LOC_HI: sel = bank_i.loc_hi;
            RA_LOC_LO: sel = bank_i.loc_lo;
            RA_REM_HI: sel = bank_i.rem_hi;
            RA_REM_LO: sel = bank_i.rem_lo;
            XA_OFFSET: sel = bank_i.offset;
            RA_ID:     sel = DEV_ID;
            RA_REV:    sel = REV_BYTE;
            default:   sel = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_q <= 8'h00;
        else if (rd_en_i) rd_q <= sel;
    end

    assign rd_data_o = rd_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rd_data_o)); // R13
    AST_RATE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && ptr_i == RA_RATE) |=> (rd_data_o[7:3] == 5'd0)); // R6
    AST_WRITE_ONLY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && ptr_i >= WA_CFG && ptr_i <= WA_TRIGGER) |=> (rd_data_o == 8'h00)); // R9
endmodule

// File: rtl/sensor_regbank.sv
module sensor_regbank
    import sensor_regbank_pkg::*;
#(
    parameter logic [7:0] DEV_ID   = 8'h41,
    parameter logic [3:0] REV_STEP = 4'h1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_en_i,
    output logic [7:0] rd_data_o,
    input  logic       meas_loc_we_i,
    input  logic [7:0] meas_loc_i,
    input  logic       meas_rem_we_i,
    input  logic [7:0] meas_rem_i,
    output logic [7:0] cfg_o,
    output logic [2:0] conv_rate_o,
    output logic [7:0] loc_high_o,
    output logic [7:0] loc_low_o,
    output logic [7:0] rem_high_o,
    output logic [7:0] rem_low_o,
    output logic [7:0] rem_offset_o,
    output logic [7:0] loc_temp_o,
    output logic [7:0] rem_temp_o,
    output logic       one_shot_o
);
    byte_t ptr;
    logic  data_we;
    wstb_t wstb;
    bank_t bank;

    regbank_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ptr_o     (ptr),
        .data_we_o (data_we)
    );

    assign wstb = decode_write(ptr, data_we);

    regbank_store u_store (
        .clk           (clk),
        .rst           (rst),
        .wstb_i        (wstb),
        .wr_data_i     (wr_data_i),
        .meas_loc_we_i (meas_loc_we_i),
        .meas_loc_i    (meas_loc_i),
        .meas_rem_we_i (meas_rem_we_i),
        .meas_rem_i    (meas_rem_i),
        .bank_o        (bank),
        .trigger_o     (one_shot_o)
    );

    regbank_rdmux #(
        .DEV_ID   (DEV_ID),
        .REV_STEP (REV_STEP)
    ) u_rdmux (
        .clk       (clk),
        .rst       (rst),
        .rd_en_i   (rd_en_i),
        .ptr_i     (ptr),
        .bank_i    (bank),
        .rd_data_o (rd_data_o)
    );

    assign cfg_o        = bank.cfg;
    assign conv_rate_o  = bank.rate;
    assign loc_high_o   = bank.loc_hi;
    assign loc_low_o    = bank.loc_lo;
    assign rem_high_o   = bank.rem_hi;
    assign rem_low_o    = bank.rem_lo;
    assign rem_offset_o = bank.offset;
    assign loc_temp_o   = bank.loc_t;
    assign rem_temp_o   = bank.rem_t;

    AST_ONESHOT_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
        one_shot_o |-> $past(wr_en_i && !start_i)); // R7
    AST_PTR_BYTE_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && start_i) |=> ($stable(cfg_o) && $stable(loc_high_o) && $stable(rem_offset_o))); // R2
endmodule

// File: tb/test_sensor_regbank.sv
module test_sensor_regbank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       meas_loc_we_i = 1'b0, meas_rem_we_i = 1'b0;
    logic [7:0] meas_loc_i = 8'h00, meas_rem_i = 8'h00;
    logic [7:0] rd_data_o, cfg_o, loc_high_o, loc_low_o, rem_high_o, rem_low_o;
    logic [7:0] rem_offset_o, loc_temp_o, rem_temp_o;
    logic [2:0] conv_rate_o;
    logic       one_shot_o;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_cfg, m_lh, m_ll, m_rh, m_rl, m_off, m_lt, m_rt, m_ptr;
    logic [2:0] m_rate;

    always #5 clk = ~clk;

    sensor_regbank i_sensor_regbank (.*);

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return m_lt;
            8'h01: return m_rt;
            8'h03: return m_cfg;
            8'h04: return {5'd0, m_rate};
            8'h05: return m_lh;
            8'h06: return m_ll;
            8'h07: return m_rh;
            8'h08: return m_rl;
            8'h11: return m_off;
            8'hFE: return 8'h41;
            8'hFF: return 8'h31;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h09: m_cfg  = d;
            8'h0A: m_rate = d[2:0];
            8'h0B: m_lh   = d;
            8'h0C: m_ll   = d;
            8'h0D: m_rh   = d;
            8'h0E: m_rl   = d;
            8'h11: m_off  = d;
            default: ;
        endcase
    endfunction

    function automatic logic [7:0] pick_addr(input int unsigned r);
        logic [7:0] tbl [16] = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h05, 8'h08, 8'h09, 8'h0A,
                                 8'h0B, 8'h0E, 8'h0F, 8'h10, 8'h11, 8'hFE, 8'hFF, 8'h20};
        return tbl[r % 16];
    endfunction

    task automatic check_fields();
        check("R12 cfg_o", cfg_o, m_cfg);
        check("R12 conv_rate_o", {5'd0, conv_rate_o}, {5'd0, m_rate});
        check("R12 loc_high_o", loc_high_o, m_lh);
        check("R12 loc_low_o", loc_low_o, m_ll);
        check("R12 rem_high_o", rem_high_o, m_rh);
        check("R12 rem_low_o", rem_low_o, m_rl);
        check("R12 rem_offset_o", rem_offset_o, m_off);
        check("R11 loc_temp_o", loc_temp_o, m_lt);
        check("R11 rem_temp_o", rem_temp_o, m_rt);
    endtask

    // pointer byte: R2
    task automatic set_ptr(input logic [7:0] a);
        start_i = 1'b1; wr_en_i = 1'b1; wr_data_i = a;
        @(negedge clk);
        start_i = 1'b0; wr_en_i = 1'b0;
        m_ptr = a;
        check("R2 no one-shot on pointer byte", {7'd0, one_shot_o}, 8'h00);
    endtask

    // data byte: R3/R5/R7/R8
    task automatic data_byte(input logic [7:0] d);
        wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        model_wr(m_ptr, d);
        check("R7 one-shot pulse", {7'd0, one_shot_o}, {7'd0, m_ptr == 8'h0F});
        @(negedge clk);
        check("R7 one-shot single cycle", {7'd0, one_shot_o}, 8'h00);
        check_fields();
    endtask

    task automatic rd_at_ptr(input string tag);
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        check(tag, rd_data_o, exp_rd(m_ptr));
    endtask

    task automatic rd_addr(input logic [7:0] a, input string tag);
        set_ptr(a);
        rd_at_ptr(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R13 watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] hold;
        void'($urandom(32'h5EED_0042));
        m_cfg = 8'h00; m_rate = 3'd2; m_lh = 8'h7F; m_ll = 8'hC9; m_rh = 8'h7F; m_rl = 8'hC9;
        m_off = 8'h00; m_lt = 8'h80; m_rt = 8'h80; m_ptr = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_data reset", rd_data_o, 8'h00);
        check_fields();
        foreach (exp_rd_list[i]) ;
        rd_addr(8'h00, "R1 local reset");
        rd_addr(8'h01, "R1 remote reset");
        rd_addr(8'h03, "R1 cfg reset");
        rd_addr(8'h04, "R1 rate reset");
        rd_addr(8'h05, "R1 loc high reset");
        rd_addr(8'h06, "R1 loc low reset");
        rd_addr(8'h07, "R1 rem high reset");
        rd_addr(8'h08, "R1 rem low reset");
        rd_addr(8'h11, "R1 offset reset");

        // R5/R4 write map then read map
        set_ptr(8'h09); data_byte(8'hC0); rd_addr(8'h03, "R4 cfg readback");
        set_ptr(8'h0B); data_byte(8'h50); rd_addr(8'h05, "R4 loc high readback");
        set_ptr(8'h0C); data_byte(8'h05); rd_addr(8'h06, "R4 loc low readback");
        set_ptr(8'h0D); data_byte(8'h66); rd_addr(8'h07, "R4 rem high readback");
        set_ptr(8'h0E); data_byte(8'hF0); rd_addr(8'h08, "R4 rem low readback");
        set_ptr(8'h11); data_byte(8'hFC); rd_addr(8'h11, "R5 offset shared address");

        // R6 rate masking
        set_ptr(8'h0A); data_byte(8'hFF); rd_addr(8'h04, "R6 rate upper bits zero");
        set_ptr(8'h0A); data_byte(8'hF8); rd_addr(8'h04, "R6 rate low bits only");

        // R3 repeated bytes to same register, pointer unchanged
        set_ptr(8'h0B); data_byte(8'h11); data_byte(8'h22); data_byte(8'h33);
        rd_at_ptr("R3 pointer held, read at write address");
        rd_addr(8'h05, "R3 last byte kept");

        // R7 trigger stores nothing
        set_ptr(8'h0F); data_byte(8'hA5);
        rd_addr(8'h0F, "R7 trigger address reads zero");

        // R8 writes to read-only / undefined addresses
        set_ptr(8'h00); data_byte(8'h12); rd_addr(8'h00, "R8 write to local reading ignored");
        set_ptr(8'h05); data_byte(8'h13); rd_addr(8'h05, "R8 write to read address ignored");
        set_ptr(8'hFE); data_byte(8'h14); rd_addr(8'hFE, "R8 write to id ignored");
        set_ptr(8'h10); data_byte(8'h15); rd_addr(8'h03, "R8 undefined write ignored");

        // R9 write-only and undefined reads
        for (int a = 9; a <= 15; a++) rd_addr(8'(a), "R9 write-only reads zero");
        rd_addr(8'h02, "R9 undefined 02");
        rd_addr(8'h20, "R9 undefined 20");

        // R10 identification
        rd_addr(8'hFE, "R10 id byte");
        set_ptr(8'hFF); rd_en_i = 1'b1; @(negedge clk); rd_en_i = 1'b0;
        check("R10 revision upper nibble", {4'd0, rd_data_o[7:4]}, 8'h03);

        // R11 measurement side port
        meas_loc_i = 8'h2A; meas_loc_we_i = 1'b1; @(negedge clk); meas_loc_we_i = 1'b0;
        m_lt = 8'h2A;
        meas_rem_i = 8'hE7; meas_rem_we_i = 1'b1; @(negedge clk); meas_rem_we_i = 1'b0;
        m_rt = 8'hE7;
        rd_addr(8'h00, "R11 local loaded");
        rd_addr(8'h01, "R11 remote loaded");

        // R13 hold without read request
        hold = rd_data_o;
        set_ptr(8'h05); set_ptr(8'hFE);
        check("R13 read data held", rd_data_o, hold);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int unsigned op;
            op = $urandom % 4;
            case (op)
                0: begin
                    set_ptr(pick_addr($urandom));
                    data_byte(8'($urandom));
                    if ($urandom % 2) data_byte(8'($urandom));
                end
                1: rd_addr(pick_addr($urandom), "R4 random read");
                2: rd_at_ptr("R3 random re-read");
                default: begin
                    if ($urandom % 2) begin
                        meas_loc_i = 8'($urandom); meas_loc_we_i = 1'b1;
                        @(negedge clk); meas_loc_we_i = 1'b0; m_lt = meas_loc_i;
                    end else begin
                        meas_rem_i = 8'($urandom); meas_rem_we_i = 1'b1;
                        @(negedge clk); meas_rem_we_i = 1'b0; m_rt = meas_rem_i;
                    end
                    check_fields();
                end
            endcase
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    logic [7:0] exp_rd_list [1] = '{8'h00};
endmodule